// File: doc/BRIEF.md
# Bidirectional Byte Mailbox Link

This block joins two processors through a pair of one-byte mailboxes. The inbound mailbox carries a byte from the remote processor to the local one, and the outbound mailbox carries a byte the other way. Each mailbox has a full flag. The flag is set when the sender writes the mailbox and cleared when the receiver reads it. A write to a mailbox that is already full is dropped, and a sticky overrun flag records it.

The local processor sees a data register and a command/status register. Four command bits enable interrupt and DMA requests separately for each direction:
- The inbound request is raised while the inbound mailbox holds a byte.
- The outbound request is raised while the outbound mailbox is free for a new byte.

The remote processor sees a data register and a status register showing both full flags. It gets an interrupt whenever a byte is waiting for it.

Register reads return data combinationally in the same cycle. Read and write side effects take effect at the clock edge on which the strobe is sampled.

Top module: `mbox_link`

## Requirements
- R1: After reset both mailboxes are empty, both overrun flags are clear, all four enable bits are zero, and `loc_irq`, `loc_dma_req` and `rem_irq` are low.
- R2: A remote write to data address 0 while the inbound mailbox is empty stores the byte and sets the inbound full flag. The flag reads as local status bit 0 and as remote status bit 7. A local read of data address 0 returns the byte, and the flag is clear from the next cycle.
- R3: A local write to data address 0 while the outbound mailbox is empty stores the byte and sets the outbound full flag. The flag reads as local status bit 7 and as remote status bit 0. A remote read of address 0 returns the byte and clears the flag.
- R4: A write to a full mailbox leaves the stored byte unchanged and sets a sticky overrun flag. The inbound overrun flag is local status bit 5 and the outbound overrun flag is local status bit 6. Each flag clears only when a local write to address 1 carries a 1 in that bit position.
- R5: A local write to address 1 loads command bits 1 to 4, which read back at the same positions of local status. Bit 1 enables the inbound interrupt, bit 2 the outbound interrupt, bit 3 the inbound DMA request and bit 4 the outbound DMA request.
- R6: `loc_irq` equals (inbound full AND bit 1) OR (outbound empty AND bit 2).
- R7: `loc_dma_req` equals (inbound full AND bit 3) OR (outbound empty AND bit 4).
- R8: `rem_irq` is high exactly while the outbound mailbox is full.
- R9: If a read of a full mailbox and a write to it fall in the same cycle, the read returns the old byte. The write counts as an overrun, and the mailbox ends empty.
- R10: Reading either status register changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_wr | input | 1 | Local write strobe |
| loc_rd | input | 1 | Local read strobe |
| loc_addr | input | 1 | Local register select: 0 data, 1 command/status |
| loc_wdata | input | DATA_W | Local write data |
| loc_rdata | output | DATA_W | Local read data |
| loc_irq | output | 1 | Interrupt to the local processor |
| loc_dma_req | output | 1 | DMA request on the local side |
| rem_wr | input | 1 | Remote write strobe |
| rem_rd | input | 1 | Remote read strobe |
| rem_addr | input | 1 | Remote register select: 0 data, 1 status |
| rem_wdata | input | DATA_W | Remote write data |
| rem_rdata | output | DATA_W | Remote read data |
| rem_irq | output | 1 | Interrupt to the remote processor |

## Verification
The hardest case to reach is a read that empties a full mailbox in the same clock edge as a new write into it. The bench fills the inbound mailbox first. In a single cycle it then raises the remote write and the local data read together. It checks that the old byte is returned, the overrun flag is set and the mailbox ends empty. It then writes again to show that the mailbox accepts new bytes. The request outputs are stepped through each enable bit on its own, with the two mailboxes held in opposite states so that each term of the OR is seen alone.

// File: rtl/mbox_link_pkg.sv
package mbox_link_pkg;
   localparam int ST_IN_FULL   = 0;
   localparam int CMD_IRQ_IN   = 1;
   localparam int CMD_IRQ_OUT  = 2;
   localparam int CMD_DMA_IN   = 3;
   localparam int CMD_DMA_OUT  = 4;
   localparam int ST_IN_OVR    = 5;
   localparam int ST_OUT_OVR   = 6;
   localparam int ST_OUT_FULL  = 7;
   localparam int REM_OUT_FULL = 0;
   localparam int REM_IN_FULL  = 7;

   typedef enum logic {
      REG_DATA = 1'b0,
      REG_CTRL = 1'b1
   } reg_sel_e;

   typedef struct packed {
      logic dma_out;
      logic dma_in;
      logic irq_out;
      logic irq_in;
   } cmd_t;
endpackage

// File: rtl/mbox_slot.sv
module mbox_slot #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd,
   input  logic              ovr_clr,
   output logic              full,
   output logic              ovr,
   output logic [DATA_W-1:0] data
);
   logic accept;
   logic reject;

   assign accept = wr && !full;
   assign reject = wr && full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else if (accept) begin
         full <= 1'b1;
         data <= wdata;
      end else if (rd) begin
         full <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ovr <= 1'b0;
      else if (reject)
         ovr <= 1'b1;
      else if (ovr_clr)
         ovr <= 1'b0;
   end

   AST_FILL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !full) |=> (full && data == $past(wdata))); // R2
   AST_FULL_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      full |=> $stable(data)); // R4
   AST_OVR_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && full) |=> ovr); // R4
   AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && full) |=> !full); // R9
endmodule

// File: rtl/mbox_req_gen.sv
module mbox_req_gen #(
   parameter bit REGISTERED = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_full,
   input  logic out_full,
   input  logic en_in,
   input  logic en_out,
   output logic req
);
   logic req_d;

   assign req_d = (in_full && en_in) || (!out_full && en_out);

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            req <= 1'b0;
         else
            req <= req_d;
      end
   end else begin : g_comb
      assign req = req_d;

      AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
         (!en_in && !en_out) |-> !req); // R6
      AST_REQ_INBOUND: assert property (@(posedge clk) disable iff (!rst_n)
         (in_full && en_in) |-> req); // R7
   end
endmodule

// File: rtl/mbox_link.sv
module mbox_link
   import mbox_link_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit REQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              loc_wr,
   input  logic              loc_rd,
   input  logic              loc_addr,
   input  logic [DATA_W-1:0] loc_wdata,
   output logic [DATA_W-1:0] loc_rdata,
   output logic              loc_irq,
   output logic              loc_dma_req,
   input  logic              rem_wr,
   input  logic              rem_rd,
   input  logic              rem_addr,
   input  logic [DATA_W-1:0] rem_wdata,
   output logic [DATA_W-1:0] rem_rdata,
   output logic              rem_irq
);
   localparam int STAT_W = 8;

   if (DATA_W < STAT_W) begin : g_bad_width
      $error("mbox_link: DATA_W must be at least 8");
   end

   logic              in_full, in_ovr, out_full, out_ovr;
   logic [DATA_W-1:0] in_data, out_data;
   logic              loc_data_wr, loc_data_rd, loc_ctrl_wr;
   logic              rem_data_wr, rem_data_rd;
   cmd_t              cmd;
   logic [DATA_W-1:0] loc_status, rem_status;

   assign loc_data_wr = loc_wr && (loc_addr == REG_DATA);
   assign loc_data_rd = loc_rd && (loc_addr == REG_DATA);
   assign loc_ctrl_wr = loc_wr && (loc_addr == REG_CTRL);
   assign rem_data_wr = rem_wr && (rem_addr == REG_DATA);
   assign rem_data_rd = rem_rd && (rem_addr == REG_DATA);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd <= '0;
      end else if (loc_ctrl_wr) begin
         cmd.irq_in  <= loc_wdata[CMD_IRQ_IN];
         cmd.irq_out <= loc_wdata[CMD_IRQ_OUT];
         cmd.dma_in  <= loc_wdata[CMD_DMA_IN];
         cmd.dma_out <= loc_wdata[CMD_DMA_OUT];
      end
   end

   mbox_slot #(.DATA_W(DATA_W)) u_inbound (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (rem_data_wr),
      .wdata   (rem_wdata),
      .rd      (loc_data_rd),
      .ovr_clr (loc_ctrl_wr && loc_wdata[ST_IN_OVR]),
      .full    (in_full),
      .ovr     (in_ovr),
      .data    (in_data)
   );

   mbox_slot #(.DATA_W(DATA_W)) u_outbound (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (loc_data_wr),
      .wdata   (loc_wdata),
      .rd      (rem_data_rd),
      .ovr_clr (loc_ctrl_wr && loc_wdata[ST_OUT_OVR]),
      .full    (out_full),
      .ovr     (out_ovr),
      .data    (out_data)
   );

   mbox_req_gen #(.REGISTERED(REQ_REG)) u_irq_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_full  (in_full),
      .out_full (out_full),
      .en_in    (cmd.irq_in),
      .en_out   (cmd.irq_out),
      .req      (loc_irq)
   );

   mbox_req_gen #(.REGISTERED(REQ_REG)) u_dma_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_full  (in_full),
      .out_full (out_full),
      .en_in    (cmd.dma_in),
      .en_out   (cmd.dma_out),
      .req      (loc_dma_req)
   );

   always_comb begin
      loc_status              = '0;
      loc_status[ST_IN_FULL]  = in_full;
      loc_status[CMD_IRQ_IN]  = cmd.irq_in;
      loc_status[CMD_IRQ_OUT] = cmd.irq_out;
      loc_status[CMD_DMA_IN]  = cmd.dma_in;
      loc_status[CMD_DMA_OUT] = cmd.dma_out;
      loc_status[ST_IN_OVR]   = in_ovr;
      loc_status[ST_OUT_OVR]  = out_ovr;
      loc_status[ST_OUT_FULL] = out_full;
      rem_status               = '0;
      rem_status[REM_OUT_FULL] = out_full;
      rem_status[REM_IN_FULL]  = in_full;
   end

   assign loc_rdata = (loc_addr == REG_CTRL) ? loc_status : in_data;
   assign rem_rdata = (rem_addr == REG_DATA) ? out_data : rem_status;
   assign rem_irq   = out_full;

   AST_REM_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_data_wr && !out_full) |=> rem_irq); // R8
   AST_CMD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      loc_ctrl_wr |=> (cmd.irq_in == $past(loc_wdata[CMD_IRQ_IN]))); // R5
   AST_STATUS_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_rd && loc_addr == REG_CTRL && !rem_wr && !loc_wr) |=> $stable(in_full)); // R10
endmodule

// File: tb/mbox_link_bench.sv
module mbox_link_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       loc_wr = 1'b0, loc_rd = 1'b0, loc_addr = 1'b0;
   logic [7:0] loc_wdata = '0;
   logic [7:0] loc_rdata;
   logic       loc_irq, loc_dma_req;
   logic       rem_wr = 1'b0, rem_rd = 1'b0, rem_addr = 1'b0;
   logic [7:0] rem_wdata = '0;
   logic [7:0] rem_rdata;
   logic       rem_irq;
   int         checks = 0;
   int         errors = 0;
   logic [7:0] v;

   always #5 clk = ~clk;

   mbox_link u_mbox_link (
      .clk(clk), .rst_n(rst_n),
      .loc_wr(loc_wr), .loc_rd(loc_rd), .loc_addr(loc_addr),
      .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
      .loc_irq(loc_irq), .loc_dma_req(loc_dma_req),
      .rem_wr(rem_wr), .rem_rd(rem_rd), .rem_addr(rem_addr),
      .rem_wdata(rem_wdata), .rem_rdata(rem_rdata), .rem_irq(rem_irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic loc_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      loc_wr = 1'b1; loc_addr = a; loc_wdata = d;
      @(negedge clk);
      loc_wr = 1'b0;
   endtask

   task automatic rem_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      rem_wr = 1'b1; rem_addr = a; rem_wdata = d;
      @(negedge clk);
      rem_wr = 1'b0;
   endtask

   task automatic loc_read(input logic a, output logic [7:0] d);
      @(negedge clk);
      loc_rd = 1'b1; loc_addr = a;
      #1 d = loc_rdata;
      @(negedge clk);
      loc_rd = 1'b0;
   endtask

   task automatic rem_read(input logic a, output logic [7:0] d);
      @(negedge clk);
      rem_rd = 1'b1; rem_addr = a;
      #1 d = rem_rdata;
      @(negedge clk);
      rem_rd = 1'b0;
   endtask

   task automatic t_reset();
      loc_read(1'b1, v);  chk("R1 local status", v, 8'h00);
      rem_read(1'b1, v);  chk("R1 remote status", v, 8'h00);
      chk("R1 irq/dma/rem_irq", {5'd0, loc_irq, loc_dma_req, rem_irq}, 8'h00);
   endtask

   task automatic t_inbound();
      rem_write(1'b0, 8'hA5);
      loc_read(1'b1, v);  chk("R2 local IBF bit0", v & 8'h01, 8'h01);
      rem_read(1'b1, v);  chk("R2 remote bit7", v & 8'h80, 8'h80);
      loc_read(1'b0, v);  chk("R2 data", v, 8'hA5);
      loc_read(1'b1, v);  chk("R2 IBF cleared", v & 8'h01, 8'h00);
   endtask

   task automatic t_outbound();
      loc_write(1'b0, 8'h3C);
      rem_read(1'b1, v);  chk("R3 remote bit0", v & 8'h01, 8'h01);
      loc_read(1'b1, v);  chk("R3 local OBF bit7", v & 8'h80, 8'h80);
      chk("R8 rem_irq high", {7'd0, rem_irq}, 8'h01);
      rem_read(1'b0, v);  chk("R3 data", v, 8'h3C);
      chk("R8 rem_irq low", {7'd0, rem_irq}, 8'h00);
      loc_read(1'b1, v);  chk("R3 OBF cleared", v & 8'h80, 8'h00);
   endtask

   task automatic t_overrun();
      rem_write(1'b0, 8'h11);
      rem_write(1'b0, 8'h22);
      loc_read(1'b1, v);  chk("R4 in overrun bit5", v & 8'h20, 8'h20);
      loc_read(1'b1, v);  chk("R10 status read keeps flags", v & 8'h21, 8'h21);
      loc_read(1'b0, v);  chk("R4 first byte kept", v, 8'h11);
      loc_write(1'b1, 8'h40);
      loc_read(1'b1, v);  chk("R4 bit5 sticky vs other clear", v & 8'h20, 8'h20);
      loc_write(1'b1, 8'h20);
      loc_read(1'b1, v);  chk("R4 bit5 cleared", v & 8'h20, 8'h00);
      loc_write(1'b0, 8'h44);
      loc_write(1'b0, 8'h55);
      loc_read(1'b1, v);  chk("R4 out overrun bit6", v & 8'h40, 8'h40);
      rem_read(1'b1, v);  chk("R10 remote status read", v & 8'h01, 8'h01);
      rem_read(1'b0, v);  chk("R4 out byte kept", v, 8'h44);
      loc_write(1'b1, 8'h40);
      loc_read(1'b1, v);  chk("R4 bit6 cleared", v & 8'h40, 8'h00);
   endtask

   task automatic t_requests();
      loc_write(1'b1, 8'h1E);
      loc_read(1'b1, v);  chk("R5 command readback", v & 8'h1E, 8'h1E);
      chk("R6 irq out-empty", {7'd0, loc_irq}, 8'h01);
      chk("R7 dma out-empty", {7'd0, loc_dma_req}, 8'h01);
      rem_write(1'b0, 8'h66);
      loc_write(1'b0, 8'h77);
      loc_write(1'b1, 8'h02);
      chk("R6 irq in-full only", {7'd0, loc_irq}, 8'h01);
      chk("R7 dma off", {7'd0, loc_dma_req}, 8'h00);
      loc_write(1'b1, 8'h04);
      chk("R6 irq out-enable while OBF", {7'd0, loc_irq}, 8'h00);
      rem_read(1'b0, v);
      chk("R6 irq after remote drains", {7'd0, loc_irq}, 8'h01);
      loc_write(1'b1, 8'h08);
      chk("R7 dma in-full", {7'd0, loc_dma_req}, 8'h01);
      chk("R6 irq disabled", {7'd0, loc_irq}, 8'h00);
      loc_read(1'b0, v);
      chk("R7 dma after drain", {7'd0, loc_dma_req}, 8'h00);
      loc_write(1'b1, 8'h10);
      chk("R7 dma out-empty only", {7'd0, loc_dma_req}, 8'h01);
      loc_write(1'b1, 8'h00);
   endtask

   task automatic t_collide();
      rem_write(1'b0, 8'h77);
      @(negedge clk);
      rem_wr = 1'b1; rem_addr = 1'b0; rem_wdata = 8'h88;
      loc_rd = 1'b1; loc_addr = 1'b0;
      #1 v = loc_rdata;
      @(negedge clk);
      rem_wr = 1'b0; loc_rd = 1'b0;
      chk("R9 old byte read", v, 8'h77);
      loc_read(1'b1, v);  chk("R9 empty + overrun", v & 8'h21, 8'h20);
      rem_write(1'b0, 8'h99);
      loc_read(1'b0, v);  chk("R9 accepts next byte", v, 8'h99);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_inbound();
      t_outbound();
      t_overrun();
      t_requests();
      t_collide();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule